// File: doc/BRIEF.md
# Peripheral Port Chip-Select and Address-Strobe Timer

This block times one access cycle on a simple external peripheral port. When a start request is accepted it drives the chip select low for a computed number of clocks and, inside that window, produces an active-low address strobe. The strobe's assert edge and release edge are each placed a programmed number of clocks after the chip-select falling edge. A zero release code switches the strobe off entirely. A one-cycle done pulse marks the end of the cycle.

Timing fields are held in a configuration register. A write strobe loads it, and reset clears it to zero. The cycle length is built from a first-beat count, an optional number of further beats and a burst count. The burst count replaces the first-beat count for the later beats only when burst timing is enabled. The configured data-path width code is reported back on the outputs. Configuration is captured when an access starts. Requests that arrive while a cycle is running are ignored.

Top module: `px_cs_timer`

## Requirements
- R1: After reset all configuration fields are zero, `cs_no` and `as_no` are high, `done_o` is low and `width_o` is 00. An access with this configuration keeps `cs_no` low for exactly 1 clock and never asserts `as_no`.
- R2: When `start_i` is high at a clock edge while no cycle is running, `cs_no` goes low in the next cycle (t=0). It stays low for T cycles, where T is the larger of the beat total (R3) and the rise code plus 1.
- R3: The beat total is (first+1) + beats*(next+1), where first is `first_cnt_i`, beats is `beats_i`, and next is `burst_cnt_i` when `burst_en_i`=1 and `first_cnt_i` when `burst_en_i`=0.
- R4: `as_no` is low exactly in the cycles t with fall <= t < rise, counted from the chip-select falling edge. A fall code of 0 asserts the strobe in the same cycle as the chip select. Codes 1 to 31 mean 1 to 31 clocks.
- R5: A rise code of 00000 disables the strobe for the whole access, whatever the fall code.
- R6: If the rise code is nonzero but not greater than the fall code, `as_no` stays high for the whole access.
- R7: `done_o` is high for exactly one cycle: the cycle t=T, which is the first cycle in which `cs_no` is high again.
- R8: A `start_i` request while the chip select is low is ignored. The running cycle keeps its length, and no new cycle starts before the done cycle.
- R9: `width_o` reports the loaded width code (00 8-bit, 01 16-bit, 10 32-bit, all with gathering; 11 wide path). `wide_o` is high only for code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Loads all configuration fields |
| as_fall_i | input | 5 | Strobe assert delay code |
| as_rise_i | input | 5 | Strobe release delay code; 0 disables the strobe |
| burst_en_i | input | 1 | Enables burst timing for later beats |
| first_cnt_i | input | 4 | First-beat length minus 1 |
| burst_cnt_i | input | 4 | Later-beat burst length minus 1 |
| beats_i | input | 3 | Number of beats after the first |
| width_i | input | 2 | Data-path width code |
| start_i | input | 1 | Access start request |
| cs_no | output | 1 | Chip select, active low |
| as_no | output | 1 | Address strobe, active low |
| done_o | output | 1 | One-cycle end-of-access pulse |
| width_o | output | 2 | Configured width code |
| wide_o | output | 1 | High for the wide data path |

## Verification
The bench builds the block with its default parameters: 5-bit delay codes, 4-bit beat counts and 3-bit beat numbers. With these values every delay code from 0 to 31 is reachable, including the case where the strobe release stretches the chip select to 32 cycles. The longest access is 128 clocks (eight beats of sixteen clocks). With these widths the bench compares burst and non-burst sums on the same counts and walks all four width codes. It checks the strobe and chip select cycle by cycle against a bench model, and it toggles start requests at random during every access.

// File: rtl/px_pkg.sv
package px_pkg;
  typedef enum logic [1:0] {
    PX_W8   = 2'b00,
    PX_W16  = 2'b01,
    PX_W32  = 2'b10,
    PX_WIDE = 2'b11
  } px_width_e;
endpackage

// File: rtl/px_cfg_regs.sv
module px_cfg_regs #(
  parameter int DLY_W  = 5,
  parameter int CNT_W  = 4,
  parameter int BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DLY_W-1:0]  fall_i,
  input  logic [DLY_W-1:0]  rise_i,
  input  logic              burst_en_i,
  input  logic [CNT_W-1:0]  first_i,
  input  logic [CNT_W-1:0]  burst_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  px_pkg::px_width_e width_i,
  output logic [DLY_W-1:0]  fall_o,
  output logic [DLY_W-1:0]  rise_o,
  output logic              burst_en_o,
  output logic [CNT_W-1:0]  first_o,
  output logic [CNT_W-1:0]  burst_o,
  output logic [BEAT_W-1:0] beats_o,
  output px_pkg::px_width_e width_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_o     <= '0;
      rise_o     <= '0;
      burst_en_o <= 1'b0;
      first_o    <= '0;
      burst_o    <= '0;
      beats_o    <= '0;
      width_o    <= px_pkg::PX_W8;
    end else if (we_i) begin
      fall_o     <= fall_i;
      rise_o     <= rise_i;
      burst_en_o <= burst_en_i;
      first_o    <= first_i;
      burst_o    <= burst_i;
      beats_o    <= beats_i;
      width_o    <= width_i;
    end
  end
endmodule

// File: rtl/px_len_calc.sv
module px_len_calc #(
  parameter int DLY_W  = 5,
  parameter int CNT_W  = 4,
  parameter int BEAT_W = 3,
  parameter int LEN_W  = 8
) (
  input  logic [DLY_W-1:0]  rise_i,
  input  logic              burst_en_i,
  input  logic [CNT_W-1:0]  first_i,
  input  logic [CNT_W-1:0]  burst_i,
  input  logic [BEAT_W-1:0] beats_i,
  output logic [LEN_W-1:0]  total_o
);
  logic [LEN_W-1:0] first_len, next_len, beat_sum, rise_len;

  always_comb begin
    first_len = LEN_W'(first_i) + LEN_W'(1);
    next_len  = burst_en_i ? LEN_W'(burst_i) + LEN_W'(1) : first_len;
    beat_sum  = first_len + LEN_W'(beats_i) * next_len;
    rise_len  = LEN_W'(rise_i) + LEN_W'(1);
    // strobe release must land inside the chip-select window
    total_o   = (rise_len > beat_sum) ? rise_len : beat_sum;
  end
endmodule

// File: rtl/px_strobe_seq.sv
module px_strobe_seq #(
  parameter int DLY_W = 5,
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] total_i,
  input  logic [DLY_W-1:0] fall_i,
  input  logic [DLY_W-1:0] rise_i,
  output logic             cs_no,
  output logic             as_no,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [LEN_W-1:0] t_q, last_q;
  logic [DLY_W-1:0] fall_q, rise_q;
  logic             at_last;

  assign at_last = (t_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      t_q    <= '0;
      last_q <= '0;
      fall_q <= '0;
      rise_q <= '0;
    end else begin
      done_q <= busy_q && at_last;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          t_q    <= '0;
          last_q <= total_i - LEN_W'(1);
          fall_q <= fall_i;
          rise_q <= rise_i;
        end
      end else if (at_last) begin
        busy_q <= 1'b0;
      end else begin
        t_q <= t_q + LEN_W'(1);
      end
    end
  end

  assign cs_no  = ~busy_q;
  assign as_no  = ~(busy_q && (rise_q != '0) &&
                    (t_q >= LEN_W'(fall_q)) && (t_q < LEN_W'(rise_q)));
  assign done_o = done_q;

  p_as_in_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_no |-> !cs_no);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o);
  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !at_last) |=> (!cs_no && t_q == $past(t_q) + LEN_W'(1)));
endmodule

// File: rtl/px_cs_timer.sv
module px_cs_timer #(
  parameter int DLY_W  = 5,
  parameter int CNT_W  = 4,
  parameter int BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DLY_W-1:0]  as_fall_i,
  input  logic [DLY_W-1:0]  as_rise_i,
  input  logic              burst_en_i,
  input  logic [CNT_W-1:0]  first_cnt_i,
  input  logic [CNT_W-1:0]  burst_cnt_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic [1:0]        width_i,
  input  logic              start_i,
  output logic              cs_no,
  output logic              as_no,
  output logic              done_o,
  output logic [1:0]        width_o,
  output logic              wide_o
);
  localparam int SUM_W = CNT_W + BEAT_W;
  localparam int LEN_W = ((SUM_W > DLY_W) ? SUM_W : DLY_W) + 1;

  logic [DLY_W-1:0]  fall_r, rise_r;
  logic              burst_en_r;
  logic [CNT_W-1:0]  first_r, burst_r;
  logic [BEAT_W-1:0] beats_r;
  px_pkg::px_width_e width_r;
  logic [LEN_W-1:0]  total;

  px_cfg_regs #(.DLY_W(DLY_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .fall_i(as_fall_i), .rise_i(as_rise_i),
    .burst_en_i, .first_i(first_cnt_i), .burst_i(burst_cnt_i), .beats_i,
    .width_i(px_pkg::px_width_e'(width_i)),
    .fall_o(fall_r), .rise_o(rise_r), .burst_en_o(burst_en_r),
    .first_o(first_r), .burst_o(burst_r), .beats_o(beats_r), .width_o(width_r)
  );

  px_len_calc #(.DLY_W(DLY_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W), .LEN_W(LEN_W)) u_len (
    .rise_i(rise_r), .burst_en_i(burst_en_r), .first_i(first_r),
    .burst_i(burst_r), .beats_i(beats_r), .total_o(total)
  );

  px_strobe_seq #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .total_i(total),
    .fall_i(fall_r), .rise_i(rise_r),
    .cs_no, .as_no, .done_o
  );

  assign width_o = width_r;
  assign wide_o  = (width_r == px_pkg::PX_WIDE);

  p_cs_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(start_i));
  p_wide_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_o |-> (width_o == 2'b11));
endmodule

// File: tb/px_cs_timer_tb_top.sv
module px_cs_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] fall = '0, rise = '0;
  logic       ben = 1'b0;
  logic [3:0] fcnt = '0, bcnt = '0;
  logic [2:0] beats = '0;
  logic [1:0] wcode = '0;
  logic       start = 1'b0;
  logic       cs_n, as_n, done, wide;
  logic [1:0] wout;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  px_cs_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we),
    .as_fall_i(fall), .as_rise_i(rise), .burst_en_i(ben),
    .first_cnt_i(fcnt), .burst_cnt_i(bcnt), .beats_i(beats),
    .width_i(wcode), .start_i(start),
    .cs_no(cs_n), .as_no(as_n), .done_o(done), .width_o(wout), .wide_o(wide)
  );

  function automatic int exp_len(int f, int b, bit be, int nb, int r);
    int nxt = be ? b + 1 : f + 1;
    int sum = (f + 1) + nb * nxt;
    return (r + 1 > sum) ? r + 1 : sum;
  endfunction

  function automatic bit exp_as_low(int t, int f, int r);
    return (r != 0) && (t >= f) && (t < r);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cfg registered fields at the time of start
  int c_f = 0, c_r = 0, c_fc = 0, c_bc = 0, c_nb = 0;
  bit c_be = 0;

  task automatic load(int f, int r, bit be, int fc, int bc, int nb, int w);
    @(negedge clk);
    fall = 5'(f); rise = 5'(r); ben = be; fcnt = 4'(fc); bcnt = 4'(bc);
    beats = 3'(nb); wcode = 2'(w); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    c_f = f; c_r = r; c_be = be; c_fc = fc; c_bc = bc; c_nb = nb;
    chk("R9 width", int'(wout), w);
    chk("R9 wide", int'(wide), (w == 3) ? 1 : 0);
  endtask

  task automatic access(bit rnd_start);
    int tt = exp_len(c_fc, c_bc, c_be, c_nb, c_r);
    start = 1'b1;
    @(negedge clk);
    for (int t = 0; t < tt; t++) begin
      chk("R2 cs low", int'(cs_n), 0);
      chk((c_r == 0) ? "R5 as off" : (c_r <= c_f) ? "R6 as off" : "R4 as",
          int'(as_n), exp_as_low(t, c_f, c_r) ? 0 : 1);
      chk("R7 no early done", int'(done), 0);
      start = (rnd_start && t < tt - 1) ? 1'($urandom_range(0, 1)) : 1'b0;
      @(negedge clk);
    end
    chk("R2 R8 cs high at T", int'(cs_n), 1);
    chk("R7 done at T", int'(done), 1);
    chk("R4 as high at T", int'(as_n), 1);
    @(negedge clk);
    chk("R7 done single", int'(done), 0);
    chk("R8 no restart", int'(cs_n), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs", int'(cs_n), 1);
    chk("R1 as", int'(as_n), 1);
    chk("R1 done", int'(done), 0);
    chk("R1 width", int'(wout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b1);                                 // R1 default access: T=1, no strobe
    load(0, 5, 0, 2, 0, 0, 0); access(1'b0);      // R4 fall 0
    load(2, 9, 0, 1, 0, 1, 1); access(1'b1);      // R4
    load(3, 3, 0, 4, 0, 0, 2); access(1'b0);      // R6 equal
    load(7, 2, 0, 9, 0, 0, 3); access(1'b1);      // R6 less
    load(6, 0, 1, 5, 2, 2, 0); access(1'b0);      // R5
    load(30, 31, 0, 0, 0, 0, 1); access(1'b1);    // R2 rise stretches to 32
    load(1, 4, 0, 3, 1, 3, 2); access(1'b0);      // R3 non-burst
    load(1, 4, 1, 3, 1, 3, 2); access(1'b0);      // R3 burst
    load(0, 1, 1, 15, 15, 7, 3); access(1'b1);    // R3 longest
    for (int i = 0; i < 40; i++) begin
      load($urandom_range(0, 31), $urandom_range(0, 31), 1'($urandom_range(0, 1)),
           $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 7),
           $urandom_range(0, 3));
      access(1'b1);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule